// File: doc/BRIEF.md
# Window-Discriminator Counting Pixel Chain

This block is the digital side of a row of photon-counting pixels. Each pixel receives two comparator flags from its analog front end, one for a low threshold and one for a high threshold. A pulse counts as a hit when the low flag rises and then falls while the high flag stays quiet, so only energies inside the window are counted. Each pixel accumulates its hits in its own counter, which saturates instead of wrapping.

The same counter register has a second role. In readout mode it is a link of a serial chain that runs from pixel to pixel, so a whole frame of counts leaves through one pin, one bit per shift enable. A separate chain of per-pixel configuration words is loaded through the same serial input in configuration mode. Each word sets the two threshold trims and three test bits; the trims go to the analog side as outputs. A synchronous clear zeroes every counter before a counting frame.

Top module: `wdc_pixel_chain`

## Requirements
- R1: In configuration mode (mode=3) each cycle with shift_en high shifts the configuration chain by one bit: chain_in enters bit 0 of the last pixel, and bit 10 of pixel i+1 enters bit 0 of pixel i. After N_PIX*11 shifts the first bit sent is bit 10 of pixel 0. Word layout: bits [10:7] high trim, [6:3] low trim, [2:0] test bits, presented on trim_hi, trim_lo and test_bits at slice [i*W +: W] for pixel i.
- R2: The configuration words do not change in any cycle that is not a configuration-mode cycle with shift_en high.
- R3: In count mode (mode=1) a pixel's counter rises by exactly one for a low-flag pulse during which the high flag never asserts; the new value is visible after the clock edge of the first cycle in which the low flag is low again.
- R4: A high flag seen in any cycle while the low flag is high discards that pulse; a high flag in the cycle the low flag has already returned low does not.
- R5: A low flag held high for many cycles counts once.
- R6: A pixel whose test bit 0 is 1 never counts.
- R7: Counters change only in count mode, readout mode with shift_en, or on clear; in idle mode (mode=0) pulses are ignored.
- R8: A counter at 4095 stays at 4095 on further hits.
- R9: clr high at a clock edge zeroes every counter, in any mode.
- R10: In readout mode (mode=2) ser_out shows bit 11 of pixel 0's counter; each shift_en cycle moves every counter left by one, bit 11 of pixel i+1 entering bit 0 of pixel i and chain_in entering bit 0 of the last pixel. A frame is pixel 0 MSB first, then pixel 1, and so on.
- R11: After reset all counters and configuration words are zero and ser_out is 0.
- R12: In configuration mode ser_out shows bit 10 of pixel 0's configuration word.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 idle, 1 count, 2 readout, 3 configuration |
| clr | input | 1 | Synchronous clear of all counters |
| shift_en | input | 1 | Shift one bit along the active chain |
| chain_in | input | 1 | Serial input at the far end of the chain |
| lo_flag | input | N_PIX | Low-threshold comparator flag per pixel |
| hi_flag | input | N_PIX | High-threshold comparator flag per pixel |
| ser_out | output | 1 | Serial output at pixel 0 |
| trim_lo | output | N_PIX*4 | Low-threshold trim per pixel |
| trim_hi | output | N_PIX*4 | High-threshold trim per pixel |
| test_bits | output | N_PIX*3 | Test bits per pixel |

## Verification
The bench targets the edges of the window rule: a high flag raised in the middle of a pulse, one raised only after the low flag has fallen, and a pulse held for several cycles; a design that sampled the high flag at the wrong moment would lose or gain a count, and one that counted on level would count a long pulse several times. It drives four thousand-odd pulses into one pixel to reach the ceiling, where a wrapping counter would read a small number. Two back-to-back readouts check that bits entering the far end travel the whole chain, which a misordered link would scramble, and pulses in idle mode and on a masked pixel must leave counts untouched.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
   typedef enum logic [1:0] {
      MD_IDLE  = 2'd0,
      MD_COUNT = 2'd1,
      MD_READ  = 2'd2,
      MD_CFG   = 2'd3
   } wdc_mode_e;

   localparam int TRIM_BITS = 4;
   localparam int TEST_BITS = 3;
   localparam int MASK_BIT  = 0;
endpackage

// File: rtl/wdc_event_det.sv
module wdc_event_det (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic lo,
   input  logic hi,
   output logic hit
);
   logic pend;
   logic veto;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         veto <= 1'b0;
      end else if (clr) begin
         pend <= 1'b0;
         veto <= 1'b0;
      end else if (!pend) begin
         if (lo) begin
            pend <= 1'b1;
            veto <= hi;
         end
      end else if (lo) begin
         veto <= veto | hi;
      end else begin
         pend <= 1'b0;
         veto <= 1'b0;
      end
   end

   // a pulse ends in the first cycle the low flag is seen low again
   assign hit = pend & ~lo & ~veto;
endmodule

// File: rtl/wdc_count_link.sv
module wdc_count_link #(
   parameter int CNT_W  = 12,
   parameter bit SAT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             shift,
   input  logic             ser_in,
   output logic [CNT_W-1:0] cnt,
   output logic             msb
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic do_inc;

   generate
      if (SAT_EN) begin : g_sat
         assign do_inc = inc && (cnt != CNT_MAX);
      end else begin : g_wrap
         assign do_inc = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (shift) begin
         cnt <= {cnt[CNT_W-2:0], ser_in};
      end else if (do_inc) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign msb = cnt[CNT_W-1];
endmodule

// File: rtl/wdc_cfg_link.sv
module wdc_cfg_link #(
   parameter int CFG_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic             ser_in,
   output logic [CFG_W-1:0] cfg,
   output logic             msb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (shift) begin
         cfg <= {cfg[CFG_W-2:0], ser_in};
      end
   end

   assign msb = cfg[CFG_W-1];
endmodule

// File: rtl/wdc_pixel_chain.sv
module wdc_pixel_chain
   import wdc_pkg::*;
#(
   parameter int N_PIX  = 4,
   parameter int CNT_W  = 12,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 mode,
   input  logic                       clr,
   input  logic                       shift_en,
   input  logic                       chain_in,
   input  logic [N_PIX-1:0]           lo_flag,
   input  logic [N_PIX-1:0]           hi_flag,
   output logic                       ser_out,
   output logic [N_PIX*TRIM_BITS-1:0] trim_lo,
   output logic [N_PIX*TRIM_BITS-1:0] trim_hi,
   output logic [N_PIX*TEST_BITS-1:0] test_bits
);
   localparam int CFG_W   = 2*TRIM_BITS + TEST_BITS;
   localparam int HI_LSB  = TRIM_BITS + TEST_BITS;
   localparam int LO_LSB  = TEST_BITS;

   generate
      if (N_PIX < 1) begin : g_bad_npix
         $error("N_PIX must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cntw
         $error("CNT_W must be at least 2");
      end
   endgenerate

   wdc_mode_e md;
   logic      count_en;
   logic      shift_cnt;
   logic      shift_cfg;

   logic [N_PIX:0]           cnt_link;
   logic [N_PIX:0]           cfg_link;
   logic [N_PIX*CNT_W-1:0]   cnt_flat;
   logic [N_PIX*CFG_W-1:0]   cfg_flat;

   assign md        = wdc_mode_e'(mode);
   assign count_en  = (md == MD_COUNT);
   assign shift_cnt = shift_en && (md == MD_READ);
   assign shift_cfg = shift_en && (md == MD_CFG);

   assign cnt_link[N_PIX] = chain_in;
   assign cfg_link[N_PIX] = chain_in;

   generate
      for (genvar i = 0; i < N_PIX; i++) begin : g_pix
         logic             hit;
         logic             inc;
         logic [CNT_W-1:0] cnt;
         logic [CFG_W-1:0] cfg;

         wdc_event_det u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .lo    (lo_flag[i]),
            .hi    (hi_flag[i]),
            .hit   (hit)
         );

         assign inc = hit && count_en && !cfg[MASK_BIT];

         wdc_count_link #(
            .CNT_W  (CNT_W),
            .SAT_EN (SAT_EN)
         ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .inc    (inc),
            .shift  (shift_cnt),
            .ser_in (cnt_link[i+1]),
            .cnt    (cnt),
            .msb    (cnt_link[i])
         );

         wdc_cfg_link #(
            .CFG_W (CFG_W)
         ) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .shift  (shift_cfg),
            .ser_in (cfg_link[i+1]),
            .cfg    (cfg),
            .msb    (cfg_link[i])
         );

         assign cnt_flat[i*CNT_W +: CNT_W]         = cnt;
         assign cfg_flat[i*CFG_W +: CFG_W]         = cfg;
         assign trim_hi[i*TRIM_BITS +: TRIM_BITS]  = cfg[HI_LSB +: TRIM_BITS];
         assign trim_lo[i*TRIM_BITS +: TRIM_BITS]  = cfg[LO_LSB +: TRIM_BITS];
         assign test_bits[i*TEST_BITS +: TEST_BITS] = cfg[0 +: TEST_BITS];
      end
   endgenerate

   assign ser_out = (md == MD_CFG) ? cfg_link[0] : cnt_link[0];
endmodule

// File: rtl/wdc_chain_chk.sv
module wdc_chain_chk #(
   parameter int N_PIX  = 4,
   parameter int CNT_W  = 12,
   parameter int CFG_W  = 11,
   parameter bit SAT_EN = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               mode,
   input logic                     clr,
   input logic                     shift_en,
   input logic                     ser_out,
   input logic [N_PIX*CNT_W-1:0]   cnt_flat,
   input logic [N_PIX*CFG_W-1:0]   cfg_flat
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R9
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_flat == '0));

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode == 2'd3 && shift_en) |=> $stable(cfg_flat));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !clr) |=> $stable(cnt_flat));

   // R10
   read_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && shift_en && !clr) ##1 (mode == 2'd2)
         |-> ser_out == $past(cnt_flat[CNT_W-2]));

   generate
      for (genvar i = 0; i < N_PIX; i++) begin : g_pc
         // R3
         step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 2'd1 && !clr) |=>
               (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W])) ||
               (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1));
         if (SAT_EN) begin : g_sat
            // R8
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (mode == 2'd1 && !clr && cnt_flat[i*CNT_W +: CNT_W] == CNT_MAX)
                  |=> cnt_flat[i*CNT_W +: CNT_W] == CNT_MAX);
         end
      end
   endgenerate
endmodule

bind wdc_pixel_chain wdc_chain_chk #(
   .N_PIX  (N_PIX),
   .CNT_W  (CNT_W),
   .CFG_W  (CFG_W),
   .SAT_EN (SAT_EN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .clr      (clr),
   .shift_en (shift_en),
   .ser_out  (ser_out),
   .cnt_flat (cnt_flat),
   .cfg_flat (cfg_flat)
);

// File: tb/wdc_pixel_chain_test.sv
module wdc_pixel_chain_test;
   localparam int N  = 4;
   localparam int CW = 12;
   localparam int FW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          clr = 1'b0;
   logic          shift_en = 1'b0;
   logic          chain_in = 1'b0;
   logic [N-1:0]  lo_flag = '0;
   logic [N-1:0]  hi_flag = '0;
   logic          ser_out;
   logic [N*4-1:0] trim_lo;
   logic [N*4-1:0] trim_hi;
   logic [N*3-1:0] test_bits;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   bit exp_q[$];
   string cur_req = "R10";
   int exp_cnt[N];
   logic [FW-1:0] cfg_word[N];

   always #2 clk = ~clk;

   wdc_pixel_chain #(.N_PIX(N), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .clr(clr), .shift_en(shift_en),
      .chain_in(chain_in), .lo_flag(lo_flag), .hi_flag(hi_flag), .ser_out(ser_out),
      .trim_lo(trim_lo), .trim_hi(trim_hi), .test_bits(test_bits)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic cyc(input logic [N-1:0] lo, input logic [N-1:0] hi);
      lo_flag = lo;
      hi_flag = hi;
      tick();
   endtask

   task automatic do_clr();
      clr = 1'b1;
      tick();
      clr = 1'b0;
      for (int i = 0; i < N; i++) exp_cnt[i] = 0;
   endtask

   // monitor: pops one expected bit per readout cycle
   always @(negedge clk) begin
      if (mon_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, cur_req, ser_out, -1);
         end else begin
            bit e;
            e = exp_q.pop_front();
            check(ser_out == e, cur_req, ser_out, e);
         end
      end
   end

   // driver: queue the expected frame, then shift it out
   task automatic readout(input logic cin, input string req);
      cur_req = req;
      for (int p = 0; p < N; p++)
         for (int b = CW - 1; b >= 0; b--)
            exp_q.push_back(exp_cnt[p][b]);
      mode = 2'd2;
      shift_en = 1'b1;
      chain_in = cin;
      mon_en = 1'b1;
      repeat (N * CW) tick();
      mon_en = 1'b0;
      shift_en = 1'b0;
      chain_in = 1'b0;
      mode = 2'd0;
      for (int i = 0; i < N; i++) exp_cnt[i] = cin ? (1 << CW) - 1 : 0;
   endtask

   task automatic check_cfg_outputs(input string req);
      for (int i = 0; i < N; i++) begin
         check(trim_hi[i*4 +: 4] == cfg_word[i][10:7], req, trim_hi[i*4 +: 4], cfg_word[i][10:7]);
         check(trim_lo[i*4 +: 4] == cfg_word[i][6:3], req, trim_lo[i*4 +: 4], cfg_word[i][6:3]);
         check(test_bits[i*3 +: 3] == cfg_word[i][2:0], req, test_bits[i*3 +: 3], cfg_word[i][2:0]);
      end
   endtask

   initial begin
      int cyc_n;
      cyc_n = 0;
      while (cyc_n < 150000) begin
         @(posedge clk);
         cyc_n++;
      end
      check(1'b0, "watchdog", cyc_n, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) exp_cnt[i] = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      @(negedge clk);
      // R11 reset state
      check(ser_out == 1'b0, "R11", ser_out, 0);
      check(trim_hi == '0 && trim_lo == '0 && test_bits == '0, "R11", trim_hi, 0);
      tick();

      // R1 load configuration: pixel 1 masked via test bit 0
      for (int i = 0; i < N; i++)
         cfg_word[i] = {4'(12 + i), 4'(i + 2), (i == 1) ? 3'b001 : 3'b110};
      mode = 2'd3;
      shift_en = 1'b1;
      for (int p = 0; p < N; p++)
         for (int b = FW - 1; b >= 0; b--) begin
            chain_in = cfg_word[p][b];
            tick();
         end
      shift_en = 1'b0;
      chain_in = 1'b0;
      @(negedge clk);
      check_cfg_outputs("R1");
      // R12 config MSB of pixel 0 on the serial output
      check(ser_out == cfg_word[0][10], "R12", ser_out, cfg_word[0][10]);
      tick();
      mode = 2'd0;
      tick();

      // counting frame
      do_clr();
      mode = 2'd1;
      // R3 clean pulses on all pixels, R6 pixel 1 masked
      repeat (3) begin
         cyc('1, '0);
         cyc('0, '0);
      end
      exp_cnt[0] += 3; exp_cnt[2] += 3; exp_cnt[3] += 3;
      // R4 veto at rise and mid-pulse on pixel 0
      cyc(4'b0001, 4'b0001); cyc('0, '0);
      cyc(4'b0001, 4'b0000); cyc(4'b0001, 4'b0001); cyc('0, '0);
      // R4 high flag only after fall on pixel 2 still counts
      cyc(4'b0100, 4'b0000); cyc(4'b0000, 4'b0100); cyc('0, '0);
      exp_cnt[2] += 1;
      // R5 long pulse on pixel 3 counts once
      repeat (5) cyc(4'b1000, '0);
      cyc('0, '0);
      exp_cnt[3] += 1;
      // R7 idle mode ignores pulses
      mode = 2'd0;
      cyc('1, '0); cyc('0, '0);
      cyc('1, '0); cyc('0, '0);
      // R10 readout frame, shifting ones into the far end
      readout(1'b1, "R10 R3 R4 R5 R6 R7");
      // R10 the ones fed in traveled the whole chain
      readout(1'b0, "R10 chain");

      // R9 clear drops counts
      mode = 2'd1;
      cyc('1, '0); cyc('0, '0);
      do_clr();
      readout(1'b0, "R9");

      // R8 saturation on pixel 2
      do_clr();
      mode = 2'd1;
      repeat (4100) begin
         cyc(4'b0100, '0);
         cyc('0, '0);
      end
      exp_cnt[2] = 4095;
      readout(1'b0, "R8");

      // R2 configuration untouched by readout shifts and counting
      @(negedge clk);
      check_cfg_outputs("R2");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule